// File: doc/BRIEF.md
# Strobed-Address Three-to-Eight Line Decoder

This block turns a three-bit select address into eight active-low strobe lines, exactly one of which goes low while the block is enabled. The address passes through a hold stage steered by a strobe input: with the strobe low the stage is transparent and the outputs follow the live select lines. The cycle in which the strobe is first seen high captures the select value. From then on the captured value alone drives the decode until the strobe drops again. A bus master can therefore present an address, strobe it in, and move the select lines on to other work without any glitch on the decoded lines.

Two enables of opposite polarity gate every output: `en_a` must be high and `en_b_n` must be low for any line to go low. With one block's enables tied to higher address bits, several blocks cascade into a wider decoder with no extra gates. The block works on a system clock. It has a synchronous active-high reset, and it detects the strobe edge from a registered copy of the strobe rather than from a level-sensitive latch.

Top module: `ladec_strobed`

## Requirements
- R1: While `addr_le` is low, the outputs decode the live `sel` value in the same cycle, with no clock edge in between.
- R2: In the first cycle in which `addr_le` is sampled high after being low, the decode shows the live `sel`, and that value is stored at the clock edge that ends the cycle.
- R3: While `addr_le` stays high after the capture cycle, changes on `sel` leave the outputs unchanged.
- R4: If `en_a` is low or `en_b_n` is high, all eight bits of `y_n` are 1, whatever `sel` and `addr_le` are.
- R5: When enabled, exactly one bit of `y_n` is 0, at index `sel[2]*4 + sel[1]*2 + sel[0]`, with `sel[0]` the least significant select bit. All other bits are 1.
- R6: Toggling the enables leaves the stored address untouched. Re-enabling shows the address captured before the outputs were disabled.
- R7: A synchronous reset clears the stored address to 0 and marks the strobe as already high. With `addr_le` high out of reset, `y_n[0]` is the low output until the strobe falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| sel | input | SEL_W (3) | Select address, bit 0 least significant |
| addr_le | input | 1 | Address strobe: low = transparent, high = hold |
| en_a | input | 1 | Active-high output enable |
| en_b_n | input | 1 | Active-low output enable |
| y_n | output | 2**SEL_W (8) | Active-low decoded lines |

## Verification
First, every select value is swept with the strobe low, which separates a correct index mapping from swapped or inverted select bits. Next come strobe sequences where `sel` moves after the rising edge. These tell a true hold apart from a decoder that stays transparent, and tell a capture on the edge cycle apart from a capture one cycle late. Each enable is driven on its own and both together, to prove the override and its polarity. Enables are then toggled over a held address, and a reset is applied with the strobe high, which shows whether the stored value survives disabling and whether reset actually clears it.

// File: rtl/ladec_pkg.sv
package ladec_pkg;

    localparam int DEF_SEL_W = 3;

    // How the hold stage treats the select lines in the current cycle.
    typedef enum logic [1:0] {
        HM_PASS    = 2'd0,   // strobe low: transparent
        HM_CAPTURE = 2'd1,   // strobe just rose: show and store live select
        HM_HOLD    = 2'd2    // strobe held high: stored value only
    } hold_mode_t;

    // The two output enables, kept together through the gating stage.
    typedef struct packed {
        logic en_a;     // active high
        logic en_b_n;   // active low
    } oe_pair_t;

    function automatic hold_mode_t classify_strobe(input logic le_now, input logic le_prev);
        if (!le_now)
            return HM_PASS;
        else if (!le_prev)
            return HM_CAPTURE;
        else
            return HM_HOLD;
    endfunction

    function automatic logic oe_active(input oe_pair_t oe);
        return oe.en_a && !oe.en_b_n;
    endfunction

endpackage

// File: rtl/ladec_addr_hold.sv
module ladec_addr_hold
    import ladec_pkg::*;
#(
    parameter int SEL_W = DEF_SEL_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SEL_W-1:0] sel,
    input  logic             le,
    output logic [SEL_W-1:0] addr_eff,
    output hold_mode_t       mode
);

    logic             le_q;
    logic [SEL_W-1:0] held_q;

    always_comb begin
        mode = classify_strobe(le, le_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            le_q   <= 1'b1;
            held_q <= '0;
        end else begin
            le_q <= le;
            if (mode != HM_HOLD)
                held_q <= sel;
        end
    end

    always_comb begin
        addr_eff = (mode == HM_HOLD) ? held_q : sel;
    end

    // R2: the value live in the capture cycle is what gets stored
    p_capture_store_r2: assert property (@(posedge clk) disable iff (rst)
        (mode == HM_CAPTURE) |=> (held_q == $past(sel)));

    // R3: during hold the decoded address does not move
    p_hold_addr_r3: assert property (@(posedge clk) disable iff (rst)
        (mode == HM_HOLD && $past(mode) == HM_HOLD && !$past(rst)) |-> $stable(addr_eff));

endmodule

// File: rtl/ladec_onehot.sv
module ladec_onehot #(
    parameter int SEL_W = 3,
    localparam int OUTS = 1 << SEL_W
) (
    input  logic [SEL_W-1:0] addr,
    output logic [OUTS-1:0]  hit
);

    for (genvar i = 0; i < OUTS; i++) begin : g_line
        assign hit[i] = (addr == SEL_W'(i));
    end

    always_comb begin
        p_hit_onehot_r5: assert ($onehot(hit) || $isunknown(addr));
    end

endmodule

// File: rtl/ladec_out_gate.sv
module ladec_out_gate
    import ladec_pkg::*;
#(
    parameter int OUTS = 8
) (
    input  logic [OUTS-1:0] hit,
    input  logic            en_a,
    input  logic            en_b_n,
    output logic [OUTS-1:0] y_n
);

    oe_pair_t oe;
    logic     live;

    always_comb begin
        oe.en_a   = en_a;
        oe.en_b_n = en_b_n;
        live      = oe_active(oe);
    end

    for (genvar i = 0; i < OUTS; i++) begin : g_drv
        assign y_n[i] = !(live && hit[i]);
    end

endmodule

// File: rtl/ladec_strobed.sv
module ladec_strobed
    import ladec_pkg::*;
#(
    parameter int SEL_W = DEF_SEL_W,
    localparam int OUTS = 1 << SEL_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SEL_W-1:0] sel,
    input  logic             addr_le,
    input  logic             en_a,
    input  logic             en_b_n,
    output logic [OUTS-1:0]  y_n
);

    logic [SEL_W-1:0] addr_eff;
    hold_mode_t       mode;
    logic [OUTS-1:0]  hit;
    logic             enabled;

    assign enabled = en_a && !en_b_n;

    ladec_addr_hold #(.SEL_W(SEL_W)) u_hold (
        .clk      (clk),
        .rst      (rst),
        .sel      (sel),
        .le       (addr_le),
        .addr_eff (addr_eff),
        .mode     (mode)
    );

    ladec_onehot #(.SEL_W(SEL_W)) u_dec (
        .addr (addr_eff),
        .hit  (hit)
    );

    ladec_out_gate #(.OUTS(OUTS)) u_gate (
        .hit    (hit),
        .en_a   (en_a),
        .en_b_n (en_b_n),
        .y_n    (y_n)
    );

    // R1: strobe low, the live select line is the low output
    p_follow_live_r1: assert property (@(posedge clk) disable iff (rst)
        (!addr_le && enabled) |-> !y_n[sel]);

    // R3: held address keeps the outputs still while enables stay on
    p_hold_outputs_r3: assert property (@(posedge clk) disable iff (rst)
        (addr_le && $past(addr_le) && !$past(rst) && enabled && $past(enabled))
        |-> $stable(y_n));

    // R4: either enable inactive forces every line high
    p_disable_all_r4: assert property (@(posedge clk) disable iff (rst)
        !enabled |-> (y_n == {OUTS{1'b1}}));

    // R5: enabled means exactly one low line
    p_one_low_r5: assert property (@(posedge clk) disable iff (rst)
        enabled |-> ($countones(~y_n) == 1));

    // R7: strobe high straight out of reset decodes address 0
    p_reset_zero_r7: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && addr_le && enabled) |-> !y_n[0]);

endmodule

// File: tb/tb_ladec_strobed.sv
module tb_ladec_strobed;

    localparam int SEL_W = 3;
    localparam int OUTS  = 1 << SEL_W;
    localparam int NVEC  = 23;

    // vector = {en_b_n, en_a, addr_le, sel[2:0]}
    localparam logic [5:0] VEC [NVEC] = '{
        6'b01_0_000, 6'b01_0_011, 6'b01_0_111, 6'b01_0_101,
        6'b01_1_101, 6'b01_1_010, 6'b01_1_001, 6'b01_1_110,
        6'b00_1_000, 6'b11_1_011, 6'b10_1_100, 6'b01_1_111,
        6'b01_0_110, 6'b01_1_110, 6'b01_1_000, 6'b01_0_000,
        6'b01_0_001, 6'b01_1_001, 6'b00_0_010, 6'b01_1_111,
        6'b01_1_011, 6'b11_1_000, 6'b01_1_100
    };

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [SEL_W-1:0] sel = '0;
    logic             addr_le = 1'b0;
    logic             en_a = 1'b1;
    logic             en_b_n = 1'b0;
    logic [OUTS-1:0]  y_n;

    int total = 0;
    int bad   = 0;
    int cycles = 0;

    ladec_strobed #(.SEL_W(SEL_W)) dut (
        .clk     (clk),
        .rst     (rst),
        .sel     (sel),
        .addr_le (addr_le),
        .en_a    (en_a),
        .en_b_n  (en_b_n),
        .y_n     (y_n)
    );

    always #10 clk = ~clk;

    // Reference state built from R2/R3/R7.
    logic             m_prev_le;
    logic [SEL_W-1:0] m_store;
    always @(posedge clk) begin
        if (rst) begin
            m_prev_le <= 1'b1;
            m_store   <= '0;
        end else begin
            if (!(addr_le && m_prev_le)) m_store <= sel;
            m_prev_le <= addr_le;
        end
    end

    function automatic logic [OUTS-1:0] model_out();
        logic [SEL_W-1:0] a;
        a = (addr_le && m_prev_le) ? m_store : sel;
        if (!en_a || en_b_n) return '1;
        return ~(OUTS'(1) << a);
    endfunction

    task automatic check(input string req, input logic [OUTS-1:0] exp);
        total++;
        if (y_n !== exp) begin
            bad++;
            $display("FAIL %s: y_n=%b expected=%b", req, y_n, exp);
        end
    endtask

    task automatic drive(input logic [5:0] v);
        @(negedge clk);
        {en_b_n, en_a, addr_le, sel} = v;
        #2;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 200000) begin
            total++;
            bad++;
            $display("FAIL watchdog: cycles=%0d expected<=200000", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #2;
        check("R7 reset state", 8'hFE);

        // Vector walk against the reference model (R1..R6)
        for (int i = 0; i < NVEC; i++) begin
            drive(VEC[i]);
            check("R1-R6 vector", model_out());
        end

        // R1/R5: exhaustive transparent sweep with fixed expectations
        for (int i = 0; i < OUTS; i++) begin
            drive({2'b01, 1'b0, 3'(i)});
            check("R1/R5 sweep", ~(8'(1) << i));
        end

        // R2: capture cycle shows live value, held afterwards
        drive(6'b01_0_101); check("R1 pre-strobe", 8'hDF);
        drive(6'b01_1_101); check("R2 capture cycle", 8'hDF);
        drive(6'b01_1_010); check("R3 sel moved while held", 8'hDF);
        drive(6'b01_1_110); check("R3 sel moved again", 8'hDF);

        // R4/R6: enables toggled over the held address
        drive(6'b00_1_011); check("R4 en_a low", 8'hFF);
        drive(6'b01_1_011); check("R6 re-enable after en_a", 8'hDF);
        drive(6'b11_1_100); check("R4 en_b_n high", 8'hFF);
        drive(6'b10_1_001); check("R4 both inactive", 8'hFF);
        drive(6'b01_1_001); check("R6 re-enable after en_b_n", 8'hDF);

        // R7: synchronous reset with strobe high clears stored address
        @(negedge clk);
        rst = 1'b1;
        sel = 3'd6;
        @(negedge clk);
        rst = 1'b0;
        #2;
        check("R7 reset clears store", 8'hFE);
        drive(6'b01_1_011); check("R7 strobe high out of reset", 8'hFE);
        drive(6'b01_0_011); check("R1 strobe falls after reset", 8'hF7);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule